// File: doc/BRIEF.md
# Edge-Configurable Interrupt Controller

This block gathers up to 32 interrupt request lines into one interrupt output. Each line first passes an input gate. A per-line sensitivity setting then decides whether a high input sets the line's pending bit on every cycle or only when the input rises. Pending bits stay set until software clears them by writing ones. A separate output-side selection decides which pending bits may raise the interrupt output. The output is signalled either as a level or as a one-cycle pulse.

Software reaches the controller through a word-indexed register port. Writes and reads each complete in one cycle, and reads are combinational from the addressed register. A small software-request register drives the lowest channels, so software can raise an interrupt by writing a one and then a zero. Cascading is done outside the block: the output of one controller is wired to a request line of another.

Top module: `irqc_top`

## Requirements
- R1: After reset every register reads zero and `irqOut` is low. The register indices are: 0 input gate, 1 output select, 2 sensitivity, 3 pending (read only), 4 clear (write only, reads zero), 5 output style, 6 software request. Index 7 reads zero and ignores writes.
- R2: A request line whose input-gate bit is 0 never sets its pending bit.
- R3: A gated-in line whose sensitivity bit is 0 is level-sensitive. Its pending bit is set after every cycle in which the line is high, so a clear written while the line stays high leaves the bit set.
- R4: A line whose sensitivity bit is 1 sets its pending bit only on a rising edge of the gated input. After a clear, a line that is held high does not set the bit again.
- R5: Writing a word to the clear register clears exactly the pending bits where the word has a 1. A 0 bit leaves its pending bit unchanged.
- R6: When a set event and a clear of the same pending bit fall in the same cycle, the bit ends up set.
- R7: With output style 0 (level), `irqOut` is high exactly while some pending bit has its output-select bit at 1. Pending bits whose select bit is 0 do not drive the output.
- R8: Bit 0 of a word written to the output style register selects the style: 1 is pulse, 0 is level. The register reads back as all ones or all zeros. In pulse style, `irqOut` is high for one cycle after each cycle in which a selected pending bit goes from 0 to 1, and is low while pending bits merely stay set.
- R9: Bit k of the software-request register (k below `SW_LINES`) is ORed into request line k ahead of the input gate. Writing 1 and then 0 to it on a rising-edge channel sets that channel's pending bit.
- R10: Reads have no side effect; reading the output select register twice returns the same value and leaves the pending bits unchanged. Write bits at or above the channel count are dropped, so they read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | N_CH | Request lines |
| wrEn | input | 1 | Write strobe for the register port |
| addr | input | 3 | Register word index |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data of the addressed register, combinational |
| irqOut | output | 1 | Combined interrupt output |

## Verification
The bench holds a level-sensitive line high through a clear. A design that let the clear win would drop the pending bit while the line is still asserted. It also holds an edge-sensitive line high across a clear, which catches a design that re-arms on a level. It then times a rising edge to land in the same cycle as a clear of that bit, where a design that lets the clear win loses the event.

In pulse style the bench confirms that the output falls after one cycle while the pending bit stays set; a level implementation would stay high. It also confirms that a deselected pending bit leaves the output low. Finally, it drives a one-cycle software request into an edge channel and writes bits above the channel count, which exposes missed pulses and over-wide registers.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    IDX_GATE   = 3'd0,
    IDX_SELECT = 3'd1,
    IDX_SENSE  = 3'd2,
    IDX_PEND   = 3'd3,
    IDX_CLEAR  = 3'd4,
    IDX_STYLE  = 3'd5,
    IDX_SWREQ  = 3'd6,
    IDX_NONE   = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic    wrGate;
    logic    wrSelect;
    logic    wrSense;
    logic    wrClear;
    logic    wrStyle;
    logic    wrSwReq;
    regIdx_t rdSel;
  } irqcStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output irqcStrobe_t       strb
);
  regIdx_t idx;

  always_comb begin
    idx          = regIdx_t'(addr);
    strb         = '0;
    strb.rdSel   = idx;
    strb.wrGate   = wrEn && (idx == IDX_GATE);
    strb.wrSelect = wrEn && (idx == IDX_SELECT);
    strb.wrSense  = wrEn && (idx == IDX_SENSE);
    strb.wrClear  = wrEn && (idx == IDX_CLEAR);
    strb.wrStyle  = wrEn && (idx == IDX_STYLE);
    strb.wrSwReq  = wrEn && (idx == IDX_SWREQ);
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int N_CH     = 32,
  parameter int DATA_W   = 32,
  parameter int SW_LINES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_CH-1:0]   irqIn,
  input  logic [DATA_W-1:0] wrData,
  input  irqcStrobe_t       strb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  logic [N_CH-1:0]     gateQ, selectQ, senseQ, pendQ, prevQ;
  logic [N_CH-1:0]     reqLine, gated, setEv, clrBits;
  logic [SW_LINES-1:0] swReqQ;
  logic                styleQ, pulseQ;

  assign clrBits = strb.wrClear ? wrData[N_CH-1:0] : '0;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (i < SW_LINES) begin : g_sw
      assign reqLine[i] = irqIn[i] | swReqQ[i];
    end else begin : g_hw
      assign reqLine[i] = irqIn[i];
    end
    assign gated[i] = reqLine[i] & gateQ[i];
    assign setEv[i] = senseQ[i] ? (gated[i] & ~prevQ[i]) : gated[i];

    always_ff @(posedge clk) begin
      if (!rstN)           pendQ[i] <= 1'b0;
      else if (setEv[i])   pendQ[i] <= 1'b1;
      else if (clrBits[i]) pendQ[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gateQ   <= '0;
      selectQ <= '0;
      senseQ  <= '0;
      prevQ   <= '0;
      swReqQ  <= '0;
      styleQ  <= 1'b0;
      pulseQ  <= 1'b0;
    end else begin
      prevQ  <= gated;
      pulseQ <= |(setEv & ~pendQ & selectQ);
      if (strb.wrGate)   gateQ   <= wrData[N_CH-1:0];
      if (strb.wrSelect) selectQ <= wrData[N_CH-1:0];
      if (strb.wrSense)  senseQ  <= wrData[N_CH-1:0];
      if (strb.wrSwReq)  swReqQ  <= wrData[SW_LINES-1:0];
      if (strb.wrStyle)  styleQ  <= wrData[0];
    end
  end

  assign irqOut = styleQ ? pulseQ : |(pendQ & selectQ);

  always_comb begin
    rdData = '0;
    unique case (strb.rdSel)
      IDX_GATE:   rdData[N_CH-1:0]     = gateQ;
      IDX_SELECT: rdData[N_CH-1:0]     = selectQ;
      IDX_SENSE:  rdData[N_CH-1:0]     = senseQ;
      IDX_PEND:   rdData[N_CH-1:0]     = pendQ;
      IDX_STYLE:  rdData               = {DATA_W{styleQ}};
      IDX_SWREQ:  rdData[SW_LINES-1:0] = swReqQ;
      default:    rdData               = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int N_CH     = 32,
  parameter int DATA_W   = 32,
  parameter int SW_LINES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_CH-1:0]   irqIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);
  irqcStrobe_t strb;

  irqc_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb)
  );

  irqc_datapath #(
    .N_CH     (N_CH),
    .DATA_W   (DATA_W),
    .SW_LINES (SW_LINES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .irqIn  (irqIn),
    .wrData (wrData),
    .strb   (strb),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_CH   = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [N_CH-1:0]   irqIn,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic [N_CH-1:0]   gateQ,
  input logic [N_CH-1:0]   senseQ,
  input logic [N_CH-1:0]   pendQ,
  input logic              styleQ
);
  logic [N_CH-1:0] clrReq;
  assign clrReq = (wrEn && addr == 3'd4) ? wrData[N_CH-1:0] : '0;

  // R5: a pending bit only falls when a clear names it
  assert_sticky_pending_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((($past(pendQ) & ~pendQ) & ~$past(clrReq)) == '0));

  // R2: a gated-off line cannot raise a pending bit
  assert_gate_blocks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (($past(~gateQ & ~pendQ) & pendQ) == '0));

  // R3 and R6: a high level line is pending next cycle, whatever was cleared
  assert_level_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (($past(gateQ & ~senseQ & irqIn) & ~pendQ) == '0));

  // R8: a pulse is only seen right after some pending bit rose
  assert_pulse_follows_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (styleQ && irqOut) |-> ((pendQ & ~$past(pendQ)) != '0));
endmodule

bind irqc_top irqc_checker #(.N_CH(N_CH), .DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .irqIn  (irqIn),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .irqOut (irqOut),
  .gateQ  (u_dp.gateQ),
  .senseQ (u_dp.senseQ),
  .pendQ  (u_dp.pendQ),
  .styleQ (u_dp.styleQ)
);

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 32;

  localparam logic [2:0] A_GATE = 3'd0, A_SEL = 3'd1, A_SENSE = 3'd2, A_PEND = 3'd3,
                         A_CLR = 3'd4, A_STYLE = 3'd5, A_SWREQ = 3'd6, A_NONE = 3'd7;

  // {expected irqOut, irqIn, expected pending}; gate 0x7F, sense 0xF0, select 0x11
  localparam logic [16:0] VECS [0:7] = '{
    17'h10101, 17'h08000, 17'h02222, 17'h11010,
    17'h1FF7F, 17'h00C0C, 17'h0C040, 17'h13333
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NCH-1:0]  irqIn = '0;
  logic            wrEn = 1'b0;
  logic [2:0]      addr = '0;
  logic [DW-1:0]   wrData = '0;
  logic [DW-1:0]   rdData;
  logic            irqOut;
  int nChecks = 0;
  int nFail = 0;
  logic [DW-1:0]   rv, rv2;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.N_CH(NCH), .DATA_W(DW), .SW_LINES(2)) u_dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state of every index
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), rv);
      check("R1 reset readback", rv, '0);
    end
    check("R1 irqOut after reset", {31'b0, irqOut}, 32'd0);

    wr(A_GATE, 32'h7F);
    wr(A_SENSE, 32'hF0);
    wr(A_SEL, 32'h11);

    // Table walk: R2 gate, R3/R4 set from quiet, R7 level output
    for (int v = 0; v < 8; v++) begin
      irqIn = VECS[v][15:8];
      tick();
      rd(A_PEND, rv);
      check("R2/R4 vector pending", rv, {24'b0, VECS[v][7:0]});
      check("R7 vector irqOut", {31'b0, irqOut}, {31'b0, VECS[v][16]});
      irqIn = '0;
      wr(A_CLR, 32'hFF);
      rd(A_PEND, rv);
      check("R5 vector cleared", rv, '0);
    end

    // R3: level line held high survives clears
    irqIn = 8'h01;
    wr(A_CLR, 32'h01);
    wr(A_CLR, 32'h01);
    rd(A_PEND, rv);
    check("R3 level held through clear", rv, 32'h01);
    irqIn = '0;
    wr(A_CLR, 32'h01);
    rd(A_PEND, rv);
    check("R3 cleared once low", rv, 32'h00);

    // R4: edge line held high does not re-arm
    irqIn = 8'h10;
    tick();
    wr(A_CLR, 32'h10);
    tick();
    rd(A_PEND, rv);
    check("R4 edge held after clear", rv, 32'h00);
    irqIn = '0;
    tick();

    // R5: selective clear and zero write
    irqIn = 8'h30;
    tick();
    wr(A_CLR, 32'h10);
    rd(A_PEND, rv);
    check("R5 selective clear", rv, 32'h20);
    wr(A_CLR, 32'h00);
    rd(A_PEND, rv);
    check("R5 zero write keeps", rv, 32'h20);
    irqIn = '0;
    wr(A_CLR, 32'hFF);

    // R6: rising edge coincides with its clear
    irqIn = 8'h40;
    wr(A_CLR, 32'h40);
    rd(A_PEND, rv);
    check("R6 set wins over clear", rv, 32'h40);
    irqIn = '0;
    wr(A_CLR, 32'hFF);

    // R7: deselected pending bit leaves output low
    irqIn = 8'h20;
    tick();
    irqIn = '0;
    check("R7 deselected low", {31'b0, irqOut}, 32'd0);
    wr(A_SEL, 32'h20);
    check("R7 selected high", {31'b0, irqOut}, 32'd1);
    wr(A_CLR, 32'h20);
    check("R7 low after clear", {31'b0, irqOut}, 32'd0);
    wr(A_SEL, 32'h11);

    // R8: pulse style
    wr(A_STYLE, 32'hFFFF_FFFF);
    rd(A_STYLE, rv);
    check("R8 style readback", rv, 32'hFFFF_FFFF);
    irqIn = 8'h10;
    tick();
    check("R8 pulse high", {31'b0, irqOut}, 32'd1);
    tick();
    check("R8 pulse one cycle", {31'b0, irqOut}, 32'd0);
    rd(A_PEND, rv);
    check("R8 pending stays", rv, 32'h10);
    irqIn = '0;
    wr(A_CLR, 32'hFF);
    wr(A_STYLE, 32'h0);

    // R9: software request pulse on an edge channel
    wr(A_SENSE, 32'hF2);
    wr(A_SWREQ, 32'h2);
    wr(A_SWREQ, 32'h0);
    rd(A_PEND, rv);
    check("R9 software pulse captured", rv, 32'h02);
    wr(A_CLR, 32'hFF);
    tick();
    rd(A_PEND, rv);
    check("R9 no retrigger", rv, 32'h00);

    // R10: read side effects and wide writes
    wr(A_GATE, 32'hFFFF_FFFF);
    rd(A_GATE, rv);
    check("R10 upper bits dropped", rv, 32'hFF);
    irqIn = 8'h08;
    tick();
    irqIn = '0;
    rd(A_SEL, rv);
    tick();
    rd(A_SEL, rv2);
    check("R10 select read repeat", rv2, rv);
    rd(A_PEND, rv);
    check("R10 pending unchanged by reads", rv, 32'h08);
    rd(A_CLR, rv);
    check("R1 clear index reads zero", rv, 32'h0);
    wr(A_NONE, 32'hFFFF_FFFF);
    rd(A_NONE, rv);
    check("R1 unused index reads zero", rv, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule